// File: doc/BRIEF.md
# Time-Triggered Periodic Pulse Generator

This block holds a small bank of trigger units, three by default. Each unit watches a free-running time-of-day value made of seconds and nanoseconds. It compares that value with a target time that has been loaded into it. When the time of day reaches the target, the unit raises its level and routes it to one chosen general-purpose output. It drops the level after a programmed pulse length. The target then moves forward by one cycle width and the unit waits for the next match. A unit runs either for a fixed number of cycles or until software stops it.

A single write port configures the units. The port carries a unit number, a 3-bit address and a 32-bit data word. Sticky status flags come out as per-unit vectors. They report completion, a failed start and a completion interrupt. The time base and the merging of the interrupt flags into a chip-level interrupt live outside this block.

Register addresses, selected by `cfg_addr`:

| Address | Content |
|---|---|
| 0 | Target nanoseconds |
| 1 | Target seconds |
| 2 | Cycle width in ns |
| 3 | Cycle count |
| 4 | Pulse width in 8 ns units |
| 5 | Control |
| 6 | Status clear |

Top module: `trig_pulse_gen`

## Requirements
- R1: A unit armed by a control write to address 5 drives its output high at the first clock edge at which the time of day is at or after its target time. In the control word, bit 0 enables the unit and bits 5:4 select the output. The target is loaded with nanoseconds at address 0 and seconds at address 1. Only the selected `gpio_out` bit rises.
- R2: Each pulse stays high for the value written to address 4, multiplied by 8 ns of time-of-day.
- R3: Pulses repeat at the target plus whole multiples of the cycle width written to address 2. A nonzero cycle count written to address 3 ends the run after that many pulses and clears `unit_active`. No further pulses follow.
- R4: A cycle count of 0 keeps the unit pulsing with no limit. In this mode `done_flag` stays low.
- R5: When the target advances, nanoseconds at or above 1,000,000,000 carry into the seconds field.
- R6: If enable is written while the time of day is already at or after the target, `err_flag` is set. The unit stays inactive and produces no pulse.
- R7: Writing the control word with bit 1 (unit reset) set stops the unit and clears `unit_active`. The output level stays where it was, including high in the middle of a pulse.
- R8: The end of a counted run sets `done_flag`. It sets `irq_flag` only if control bit 2 (notify) was set when the unit was armed.
- R9: The flags are sticky. Writing address 6 clears each flag whose bit is 1: bit 0 clears done, bit 1 clears error, bit 2 clears interrupt. Flags whose bit is 0 keep their value.
- R10: After reset, every output, every flag and every active indication is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tod_sec | input | 32 | Time of day, seconds |
| tod_ns | input | 30 | Time of day, nanoseconds (0 to 999,999,999) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_unit | input | 2 | Unit addressed by the write |
| cfg_addr | input | 3 | Register address within the unit |
| cfg_wdata | input | 32 | Write data |
| gpio_out | output | 4 | Trigger outputs, OR of the unit levels routed to each |
| unit_active | output | 3 | Unit is armed or pulsing |
| done_flag | output | 3 | Counted run finished |
| err_flag | output | 3 | Start refused, target already passed |
| irq_flag | output | 3 | Completion interrupt, notify only |

## Verification
Single-shot, counted, unlimited and second-crossing schedules are each run against a time of day that the bench advances by 4 ns every clock. Edge times are measured on that same time base, so a wrong compare, an off-by-one in the pulse-width scaling or a lost nanosecond carry shows up as a specific number of nanoseconds. A target already passed at enable time separates a refused start from a late fire. A reset issued mid-pulse, followed by a long wait, separates "level held" from "level cleared". Partial clear writes show whether each status bit is cleared on its own.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int SEC_W     = 32;
    localparam int NS_W      = 30;
    localparam int DELTA_W   = 32;
    localparam int MAX_WRAPS = 5;
    localparam longint unsigned NS_PER_SEC = 64'd1000000000;

    // register addresses within one unit
    localparam logic [2:0] A_TGT_NS  = 3'd0;
    localparam logic [2:0] A_TGT_SEC = 3'd1;
    localparam logic [2:0] A_CYC_W   = 3'd2;
    localparam logic [2:0] A_CYC_CNT = 3'd3;
    localparam logic [2:0] A_PW      = 3'd4;
    localparam logic [2:0] A_CTRL    = 3'd5;
    localparam logic [2:0] A_STAT    = 3'd6;

    // control and status bit positions
    localparam int CB_EN      = 0;
    localparam int CB_RST     = 1;
    localparam int CB_NOTIFY  = 2;
    localparam int CB_GSEL_LO = 4;
    localparam int SB_DONE    = 0;
    localparam int SB_ERR     = 1;
    localparam int SB_IRQ     = 2;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } ptime_t;

    typedef enum logic [1:0] {
        U_IDLE = 2'd0,
        U_WAIT = 2'd1,
        U_HIGH = 2'd2
    } ustate_t;

    // true once 'now' has reached or passed 'tgt'
    function automatic logic time_reached(ptime_t now, ptime_t tgt);
        return (now.sec > tgt.sec) ||
               ((now.sec == tgt.sec) && (now.ns >= tgt.ns));
    endfunction

    // add a nanosecond delta, folding whole seconds into the seconds field
    function automatic ptime_t time_add(ptime_t t, logic [DELTA_W-1:0] delta);
        logic [DELTA_W+1:0] sum;
        logic [2:0]         carry;
        ptime_t             r;
        sum   = (DELTA_W+2)'(t.ns) + (DELTA_W+2)'(delta);
        carry = '0;
        for (int k = 0; k < MAX_WRAPS; k++) begin
            if (sum >= (DELTA_W+2)'(NS_PER_SEC)) begin
                sum   = sum - (DELTA_W+2)'(NS_PER_SEC);
                carry = carry + 3'd1;
            end
        end
        r.sec = t.sec + SEC_W'(carry);
        r.ns  = sum[NS_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/tpg_unit.sv
module tpg_unit
    import tpg_pkg::*;
#(
    parameter int CW_W   = 32,
    parameter int CNT_W  = 16,
    parameter int PW_W   = 24,
    parameter int GSEL_W = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  ptime_t            now,
    input  logic              wr_sel,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              level,
    output logic [GSEL_W-1:0] gsel,
    output logic              active,
    output logic              done,
    output logic              err,
    output logic              irq
);

    localparam int PW_NS_W = PW_W + 3;

    ptime_t          tgt;
    ptime_t          pend;
    logic [CW_W-1:0] cyc_w;
    logic [CNT_W-1:0] cyc_cnt;
    logic [CNT_W-1:0] fired;
    logic [PW_W-1:0] pw;
    logic            notify_q;
    ustate_t         st;

    logic             wr_ctrl, wr_stat, hit_tgt, hit_end, last_cyc, fin, arm_fail;
    logic [CNT_W-1:0] fired_nx;

    always_comb begin
        wr_ctrl  = wr_sel && (wr_addr == A_CTRL);
        wr_stat  = wr_sel && (wr_addr == A_STAT);
        hit_tgt  = time_reached(now, tgt);
        hit_end  = time_reached(now, pend);
        fired_nx = fired + CNT_W'(1);
        last_cyc = (cyc_cnt != '0) && (fired_nx == cyc_cnt);
        fin      = (st == U_HIGH) && hit_end && last_cyc && !wr_ctrl;
        arm_fail = wr_ctrl && !wr_data[CB_RST] && wr_data[CB_EN] && hit_tgt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt      <= '0;
            pend     <= '0;
            cyc_w    <= '0;
            cyc_cnt  <= '0;
            fired    <= '0;
            pw       <= '0;
            gsel     <= '0;
            notify_q <= 1'b0;
            st       <= U_IDLE;
            level    <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            irq      <= 1'b0;
        end else begin
            // sequencing; a control write takes precedence over progress
            if (wr_ctrl) begin
                if (wr_data[CB_RST]) begin
                    st <= U_IDLE;          // level deliberately untouched
                end else begin
                    notify_q <= wr_data[CB_NOTIFY];
                    gsel     <= wr_data[CB_GSEL_LO +: GSEL_W];
                    fired    <= '0;
                    if (wr_data[CB_EN] && !hit_tgt)
                        st <= U_WAIT;
                    else
                        st <= U_IDLE;
                end
            end else begin
                case (st)
                    U_WAIT: begin
                        if (hit_tgt) begin
                            level <= 1'b1;
                            st    <= U_HIGH;
                            pend  <= time_add(tgt, DELTA_W'({pw, 3'b000}));
                        end
                    end
                    U_HIGH: begin
                        if (hit_end) begin
                            level <= 1'b0;
                            fired <= fired_nx;
                            tgt   <= time_add(tgt, DELTA_W'(cyc_w));
                            st    <= last_cyc ? U_IDLE : U_WAIT;
                        end
                    end
                    default: ;
                endcase
            end

            // configuration words; software writes win over the advance
            if (wr_sel) begin
                case (wr_addr)
                    A_TGT_NS:  tgt.ns  <= wr_data[NS_W-1:0];
                    A_TGT_SEC: tgt.sec <= wr_data[SEC_W-1:0];
                    A_CYC_W:   cyc_w   <= wr_data[CW_W-1:0];
                    A_CYC_CNT: cyc_cnt <= wr_data[CNT_W-1:0];
                    A_PW:      pw      <= wr_data[PW_W-1:0];
                    default: ;
                endcase
            end

            // sticky flags, setting beats clearing in the same cycle
            done <= fin | (done & ~(wr_stat & wr_data[SB_DONE]));
            err  <= arm_fail | (err & ~(wr_stat & wr_data[SB_ERR]));
            irq  <= (fin & notify_q) | (irq & ~(wr_stat & wr_data[SB_IRQ]));
        end
    end

    assign active = (st != U_IDLE);

endmodule

// File: rtl/tpg_out_mux.sv
module tpg_out_mux #(
    parameter int N_UNITS = 3,
    parameter int N_GPIO  = 4,
    parameter int GSEL_W  = 2
) (
    input  logic [N_UNITS-1:0]        lvl,
    input  logic [N_UNITS*GSEL_W-1:0] gsel_all,
    output logic [N_GPIO-1:0]         gpio
);

    always_comb begin
        gpio = '0;
        for (int g = 0; g < N_GPIO; g++) begin
            for (int u = 0; u < N_UNITS; u++) begin
                if (lvl[u] && (gsel_all[u*GSEL_W +: GSEL_W] == GSEL_W'(g)))
                    gpio[g] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen
    import tpg_pkg::*;
#(
    parameter int N_UNITS = 3,
    parameter int N_GPIO  = 4,
    parameter int CW_W    = 32,
    parameter int CNT_W   = 16,
    parameter int PW_W    = 24,
    parameter int DATA_W  = 32,
    localparam int UIDX_W = $clog2(N_UNITS),
    localparam int GSEL_W = $clog2(N_GPIO)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEC_W-1:0]  tod_sec,
    input  logic [NS_W-1:0]   tod_ns,
    input  logic              cfg_we,
    input  logic [UIDX_W-1:0] cfg_unit,
    input  logic [2:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [N_GPIO-1:0] gpio_out,
    output logic [N_UNITS-1:0] unit_active,
    output logic [N_UNITS-1:0] done_flag,
    output logic [N_UNITS-1:0] err_flag,
    output logic [N_UNITS-1:0] irq_flag
);

    ptime_t                    now;
    logic [N_UNITS-1:0]        lvl;
    logic [N_UNITS*GSEL_W-1:0] gsel_all;

    assign now.sec = tod_sec;
    assign now.ns  = tod_ns;

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        logic sel;
        assign sel = cfg_we && (cfg_unit == UIDX_W'(u));

        tpg_unit #(
            .CW_W   (CW_W),
            .CNT_W  (CNT_W),
            .PW_W   (PW_W),
            .GSEL_W (GSEL_W),
            .DATA_W (DATA_W)
        ) u_unit (
            .clk     (clk),
            .rst     (rst),
            .now     (now),
            .wr_sel  (sel),
            .wr_addr (cfg_addr),
            .wr_data (cfg_wdata),
            .level   (lvl[u]),
            .gsel    (gsel_all[u*GSEL_W +: GSEL_W]),
            .active  (unit_active[u]),
            .done    (done_flag[u]),
            .err     (err_flag[u]),
            .irq     (irq_flag[u])
        );
    end

    tpg_out_mux #(
        .N_UNITS (N_UNITS),
        .N_GPIO  (N_GPIO),
        .GSEL_W  (GSEL_W)
    ) u_mux (
        .lvl      (lvl),
        .gsel_all (gsel_all),
        .gpio     (gpio_out)
    );

endmodule

// File: rtl/tpg_chk.sv
module tpg_chk #(
    parameter int N_UNITS = 3,
    parameter int N_GPIO  = 4,
    parameter int UIDX_W  = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               cfg_we,
    input logic [UIDX_W-1:0]  cfg_unit,
    input logic [2:0]         cfg_addr,
    input logic [N_GPIO-1:0]  gpio_out,
    input logic [N_UNITS-1:0] unit_active,
    input logic [N_UNITS-1:0] done_flag,
    input logic [N_UNITS-1:0] err_flag,
    input logic [N_UNITS-1:0] irq_flag
);

    for (genvar u = 0; u < N_UNITS; u++) begin : g_u
        logic clr_wr;
        assign clr_wr = cfg_we && (cfg_unit == UIDX_W'(u)) && (cfg_addr == 3'd6);

        p_done_ends_run_r3: assert property (@(posedge clk) disable iff (rst)
            $rose(done_flag[u]) |-> !unit_active[u]);

        p_irq_needs_done_r8: assert property (@(posedge clk) disable iff (rst)
            $rose(irq_flag[u]) |-> done_flag[u]);

        p_err_stays_idle_r6: assert property (@(posedge clk) disable iff (rst)
            $rose(err_flag[u]) |-> !unit_active[u]);

        p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
            (done_flag[u] && !clr_wr) |=> done_flag[u]);

        p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
            (err_flag[u] && !clr_wr) |=> err_flag[u]);
    end

    for (genvar g = 0; g < N_GPIO; g++) begin : g_o
        p_rise_from_active_r1: assert property (@(posedge clk) disable iff (rst)
            ($rose(gpio_out[g]) && !$past(cfg_we)) |-> (|unit_active));
    end

endmodule

bind trig_pulse_gen tpg_chk #(
    .N_UNITS (N_UNITS),
    .N_GPIO  (N_GPIO),
    .UIDX_W  (UIDX_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_unit    (cfg_unit),
    .cfg_addr    (cfg_addr),
    .gpio_out    (gpio_out),
    .unit_active (unit_active),
    .done_flag   (done_flag),
    .err_flag    (err_flag),
    .irq_flag    (irq_flag)
);

// File: tb/trig_pulse_gen_tb.sv
`timescale 1ns/1ps
module trig_pulse_gen_tb;

    localparam longint NSS = 64'd1000000000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] tod_sec;
    logic [29:0] tod_ns;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_unit = '0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  gpio_out;
    logic [2:0]  unit_active, done_flag, err_flag, irq_flag;

    logic        jump_req = 1'b1;
    logic [31:0] jump_sec = '0;
    logic [29:0] jump_ns  = '0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    trig_pulse_gen u_dut (
        .clk(clk), .rst(rst), .tod_sec(tod_sec), .tod_ns(tod_ns),
        .cfg_we(cfg_we), .cfg_unit(cfg_unit), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .gpio_out(gpio_out), .unit_active(unit_active),
        .done_flag(done_flag), .err_flag(err_flag), .irq_flag(irq_flag)
    );

    always #2 clk = ~clk;

    // time of day: +4 ns per clock, nanosecond wrap, optional jump
    always @(posedge clk) begin
        if (jump_req) begin
            tod_sec <= jump_sec;
            tod_ns  <= jump_ns;
        end else if (tod_ns >= 30'd999999996) begin
            tod_sec <= tod_sec + 32'd1;
            tod_ns  <= tod_ns + 30'd4 - 30'd1000000000;
        end else begin
            tod_ns <= tod_ns + 30'd4;
        end
    end

    function automatic longint tot_now();
        return longint'(tod_sec) * NSS + longint'(tod_ns);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_tod(input longint t);
        @(negedge clk);
        jump_sec = 32'(t / NSS);
        jump_ns  = 30'(t % NSS);
        jump_req = 1'b1;
        @(negedge clk);
        jump_req = 1'b0;
    endtask

    task automatic wr(input int u, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_unit = 2'(u); cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic prog(input int u, input longint tgt, input int cyc, input int cnt,
                        input int pw, input int gsel, input bit notify);
        wr(u, 3'd0, 32'(tgt % NSS));
        wr(u, 3'd1, 32'(tgt / NSS));
        wr(u, 3'd2, 32'(cyc));
        wr(u, 3'd3, 32'(cnt));
        wr(u, 3'd4, 32'(pw));
        wr(u, 3'd5, 32'(1 | (int'(notify) << 2) | (gsel << 4)));
    endtask

    // wait for gpio bit g to reach 'lvl'; t is the time of day the design saw
    task automatic wait_lvl(input int g, input bit lvl, input int maxc,
                            output longint t, output bit ok);
        ok = 1'b0; t = 0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (gpio_out[g] == lvl) begin
                t = tot_now() - 4;
                ok = 1'b1;
                return;
            end
        end
    endtask

    task automatic t_reset();
        chk(gpio_out == 4'd0, "R10 gpio after reset", gpio_out, 0);
        chk(unit_active == 3'd0, "R10 active after reset", unit_active, 0);
        chk((done_flag | err_flag | irq_flag) == 3'd0, "R10 flags after reset",
            done_flag | err_flag | irq_flag, 0);
    endtask

    task automatic t_single();
        longint tg, t; bit ok;
        tg = tot_now() + 800;
        prog(0, tg, 1000, 1, 5, 1, 1'b1);
        wait_lvl(1, 1'b1, 400, t, ok);
        chk(ok && t == tg, "R1 rise at target", t, tg);
        chk(gpio_out == 4'b0010, "R1 only selected output", gpio_out, 2);
        wait_lvl(1, 1'b0, 400, t, ok);
        chk(ok && t == tg + 40, "R2 width 5x8ns", t, tg + 40);
        @(negedge clk);
        chk(done_flag[0] && irq_flag[0], "R8 done and irq with notify",
            {done_flag[0], irq_flag[0]}, 3);
        chk(!unit_active[0], "R3 single run ends", unit_active[0], 0);
        wr(0, 3'd6, 32'h7);
        @(negedge clk);
        chk(!done_flag[0] && !irq_flag[0], "R9 clear all", {done_flag[0], irq_flag[0]}, 0);
    endtask

    task automatic t_count();
        longint tg, t; bit ok;
        tg = tot_now() + 800;
        prog(1, tg, 400, 3, 10, 2, 1'b0);
        for (int k = 0; k < 3; k++) begin
            wait_lvl(2, 1'b1, 400, t, ok);
            chk(ok && t == tg + k * 400, "R3 periodic rise", t, tg + k * 400);
            wait_lvl(2, 1'b0, 400, t, ok);
            chk(ok && t == tg + k * 400 + 80, "R2 width 10x8ns", t, tg + k * 400 + 80);
        end
        @(negedge clk);
        chk(done_flag[1] && !unit_active[1], "R3 stops after count",
            {done_flag[1], unit_active[1]}, 2);
        chk(!irq_flag[1], "R8 no irq without notify", irq_flag[1], 0);
        wait_lvl(2, 1'b1, 300, t, ok);
        chk(!ok, "R3 no extra pulse", ok, 0);
        wr(1, 3'd6, 32'h2);
        @(negedge clk);
        chk(done_flag[1], "R9 done kept on err-only clear", done_flag[1], 1);
        wr(1, 3'd6, 32'h1);
        @(negedge clk);
        chk(!done_flag[1], "R9 done cleared", done_flag[1], 0);
    endtask

    task automatic t_infinite();
        longint tg, t; bit ok;
        tg = tot_now() + 800;
        prog(0, tg, 240, 0, 3, 0, 1'b1);
        for (int k = 0; k < 6; k++) begin
            wait_lvl(0, 1'b1, 400, t, ok);
            chk(ok && t == tg + k * 240, "R4 unlimited rise", t, tg + k * 240);
            wait_lvl(0, 1'b0, 400, t, ok);
        end
        chk(unit_active[0] && !done_flag[0], "R4 still running",
            {unit_active[0], done_flag[0]}, 2);
        wr(0, 3'd5, 32'h2);
        @(negedge clk);
        chk(!unit_active[0], "R7 reset stops unit", unit_active[0], 0);
        wait_lvl(0, 1'b1, 200, t, ok);
        chk(!ok, "R7 no pulse after reset", ok, 0);
    endtask

    task automatic t_wrap();
        longint tg, t; bit ok;
        set_tod(7 * NSS + 999999000);
        tg = 7 * NSS + 999999600;
        prog(0, tg, 800, 2, 2, 0, 1'b0);
        wait_lvl(0, 1'b1, 400, t, ok);
        chk(ok && t == tg, "R5 first rise", t, tg);
        wait_lvl(0, 1'b0, 400, t, ok);
        wait_lvl(0, 1'b1, 400, t, ok);
        chk(ok && t == 8 * NSS + 400, "R5 carry into seconds", t, 8 * NSS + 400);
        wait_lvl(0, 1'b0, 400, t, ok);
        @(negedge clk);
        chk(done_flag[0], "R3 two-pulse run done", done_flag[0], 1);
        wr(0, 3'd6, 32'h7);
    endtask

    task automatic t_past();
        longint tg, t; bit ok;
        tg = tot_now() - 400;
        prog(2, tg, 200, 0, 2, 3, 1'b1);
        @(negedge clk);
        chk(err_flag[2] && !unit_active[2], "R6 late enable refused",
            {err_flag[2], unit_active[2]}, 2);
        wait_lvl(3, 1'b1, 200, t, ok);
        chk(!ok, "R6 no pulse", ok, 0);
        wr(2, 3'd6, 32'h1);
        @(negedge clk);
        chk(err_flag[2], "R9 err kept on done-only clear", err_flag[2], 1);
        wr(2, 3'd6, 32'h2);
        @(negedge clk);
        chk(!err_flag[2], "R9 err cleared", err_flag[2], 0);
    endtask

    task automatic t_reset_hold();
        longint tg, t; bit ok;
        tg = tot_now() + 800;
        prog(2, tg, 100000, 0, 1000, 3, 1'b0);
        wait_lvl(3, 1'b1, 400, t, ok);
        chk(ok && t == tg, "R1 rise on output 3", t, tg);
        wr(2, 3'd5, 32'h2);
        repeat (4) @(negedge clk);
        chk(!unit_active[2] && gpio_out[3], "R7 level held after reset",
            {unit_active[2], gpio_out[3]}, 1);
        repeat (2100) @(negedge clk);
        chk(gpio_out[3], "R7 level held past pulse end", gpio_out[3], 1);
        tg = tot_now() + 800;
        prog(2, tg, 400, 1, 2, 3, 1'b0);
        wait_lvl(3, 1'b0, 600, t, ok);
        chk(ok && t == tg + 16, "R2 rearmed pulse ends", t, tg + 16);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        jump_req = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_count();
        t_infinite();
        t_wrap();
        t_past();
        t_reset_hold();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule